// File: doc/BRIEF.md
# IrDA SIR Infrared Pulse Codec

This block sits between a UART's serial pins and an infrared transceiver. On the transmit path it watches the NRZ serial line and turns every zero bit into a short high pulse on the infrared drive output. The output stays dark while the line rests high. On the receive path it resynchronises the photodiode signal. Each pulse edge it sees becomes a low serial bit for the UART.

All logic runs on one clock, `clk`, which serves as the crystal clock. A select input picks the timing source. With the select low, every `clk` cycle is a timing step. With it high, only the cycles flagged by `baud_tick` count; that strobe stands for a clock at 16 times the baud rate. Normal encoding places a 3-step pulse inside each 16-step bit cell. A monoshot mode instead fires a fixed 6-cycle pulse on each falling edge of the serial input. That mode works only with the crystal timing source.

Top module: `irda_sir_codec`

## Requirements
- R1: While `rst_n` is low and just after it is released, `ir_tx` is 0 and `rxd` is 1.
- R2: While `txd` stays high, `ir_tx` stays 0.
- R3: In normal mode, a falling `txd` sampled at timing step S0 opens a 16-step bit cell. `ir_tx` is high for steps S0+7 through S0+9 only, which makes it 3 steps wide.
- R4: A zero still present on `txd` when a cell ends opens the next cell at once. Every zero bit in a run therefore gets its own 3-step pulse, 16 steps after the previous one.
- R5: With `use_baud_tick` = 1, only cycles with `baud_tick` = 1 are timing steps. Pulse offset and width scale with the strobe period.
- R6: With `mono_en` = 1 and `use_baud_tick` = 0, a falling `txd` makes `ir_tx` high for exactly 6 `clk` cycles. The pulse starts on the edge that samples the fall. Each falling edge gives one pulse, not each zero bit.
- R7: In monoshot mode, a falling edge that arrives during an active pulse neither restarts nor lengthens it.
- R8: With `use_baud_tick` = 1, `mono_en` has no effect, and the normal 3-step encoding is used.
- R9: `ir_rx` passes through two synchronising flops. A rising edge on it drives `rxd` low three `clk` edges after the input rises. With the crystal source, `rxd` is held low for 16 steps.
- R10: A high glitch on `ir_rx` that starts and ends between two rising `clk` edges leaves `rxd` high.
- R11: Infrared pulses 16 steps apart keep `rxd` low without a gap, for 16 steps per pulse.
- R12: A rising edge on `ir_rx` during a hold restarts the 16-step hold from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16x baud rate, used when `use_baud_tick` is 1 |
| use_baud_tick | input | 1 | 1: time from `baud_tick`; 0: every `clk` cycle is a step |
| mono_en | input | 1 | Selects the fixed-width monoshot transmit mode |
| txd | input | 1 | NRZ serial data from the UART, idle high |
| ir_tx | output | 1 | Infrared drive, high during a pulse |
| ir_rx | input | 1 | Infrared receive input, high during a pulse, asynchronous |
| rxd | output | 1 | Recovered NRZ serial data for the UART, idle high |

## Verification
The bench sweeps several bytes through the encoder at strobe periods of 1, 2, 3 and 5. It checks pulse count, total high time and the offset of the first pulse. A cell counter that did not rearm on a run of zeros would lose pulses. An offset or width counted in clock cycles instead of steps would break at every period above one. In monoshot mode the bench sends a second falling edge during the pulse; a retriggering design would stretch the pulse past 6 cycles. A sub-cycle glitch, a retriggered hold and a chain of receive pulses 16 steps apart probe the decoder. A decoder without a synchroniser, or one that ignored edges while holding, would fail these tests with a false zero, a short low or a gap in `rxd`.

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
  parameter int CELL        = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3,
  parameter int MONO_LEN    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic use_baud_tick,
  input  logic mono_en,
  input  logic txd,
  output logic ir_tx,
  input  logic ir_rx,
  output logic rxd
);
  localparam int CW = $clog2(CELL);
  localparam logic [CW-1:0] LAST  = CW'(CELL - 1);
  localparam logic [CW-1:0] P_LO  = CW'(PULSE_START);
  localparam logic [CW-1:0] P_HI  = CW'(PULSE_START + PULSE_LEN - 1);
  localparam logic [CW-1:0] M_END = CW'(MONO_LEN - 1);

  logic step;
  logic mono_sel;
  assign step     = use_baud_tick ? baud_tick : 1'b1;
  assign mono_sel = mono_en & ~use_baud_tick;

  logic          txd_q, tbusy, mono_q;
  logic [CW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd_q  <= 1'b1;
      tbusy  <= 1'b0;
      mono_q <= 1'b0;
      tcnt   <= '0;
    end else if (step) begin
      txd_q <= txd;
      if (!tbusy) begin
        if (txd_q && !txd) begin
          tbusy  <= 1'b1;
          tcnt   <= '0;
          mono_q <= mono_sel;
        end
      end else if (mono_q) begin
        if (tcnt == M_END) tbusy <= 1'b0;
        else               tcnt  <= tcnt + 1'b1;
      end else if (tcnt == LAST) begin
        tcnt  <= '0;
        tbusy <= ~txd;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign ir_tx = tbusy & (mono_q | (tcnt >= P_LO && tcnt <= P_HI));

  logic          rx_s1, rx_s2, rx_s3, rbusy, rx_rise;
  logic [CW-1:0] rcnt;
  assign rx_rise = rx_s2 & ~rx_s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {rx_s1, rx_s2, rx_s3} <= 3'b000;
      rbusy <= 1'b0;
      rcnt  <= '0;
    end else begin
      {rx_s1, rx_s2, rx_s3} <= {ir_rx, rx_s1, rx_s2};
      if (rx_rise) begin
        rbusy <= 1'b1;
        rcnt  <= '0;
      end else if (step && rbusy) begin
        if (rcnt == LAST) rbusy <= 1'b0;
        else              rcnt  <= rcnt + 1'b1;
      end
    end
  end

  assign rxd = ~rbusy;

  a_r7_mono_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (tbusy && mono_q && step && tcnt != M_END) |=> (tbusy && tcnt == $past(tcnt) + 1'b1));

  a_r8_mono_needs_crystal: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tbusy) && mono_q) |-> !$past(use_baud_tick));

  a_r9_rx_edge_to_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_s2) |=> !rxd);

  a_r12_rx_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd) |=> !rxd);
endmodule

// File: tb/tb_irda_sir_codec.sv
module tb_irda_sir_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b1;
  logic use_baud_tick = 1'b0;
  logic mono_en = 1'b0;
  logic txd = 1'b1;
  logic ir_rx = 1'b0;
  logic ir_tx, rxd;

  int checks = 0;
  int failures = 0;
  int p_cur = 1;
  int phase = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irda_sir_codec dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .use_baud_tick(use_baud_tick),
    .mono_en(mono_en), .txd(txd), .ir_tx(ir_tx), .ir_rx(ir_rx), .rxd(rxd)
  );

  always @(negedge clk) begin
    phase = (phase + 1 >= p_cur) ? 0 : phase + 1;
    baud_tick = (phase == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic align(input int p);
    p_cur = p;
    repeat (2 * p + 2) @(negedge clk);
    forever begin
      @(posedge clk); #1;
      if ((phase + 1) % p_cur == 0) break;
    end
    @(negedge clk);
  endtask

  task automatic run_tx(input int p, input logic [7:0] data, input bit mono);
    logic [11:0] bits;
    int zeros, falls, rises, high, first, n;
    bit mono_eff, prev;
    string tag;
    bits = {1'b1, 1'b1, data[7], data[6], data[5], data[4], data[3], data[2],
            data[1], data[0], 1'b0, 1'b1};
    mono_eff = mono && (p == 1);
    zeros = 0; falls = 0;
    for (int i = 0; i < 12; i++) begin
      if (!bits[i]) zeros++;
      if (i > 0 && bits[i-1] && !bits[i]) falls++;
    end
    use_baud_tick = (p > 1);
    mono_en = mono;
    align(p);
    rises = 0; high = 0; first = -1; prev = 0;
    n = 12 * 16 * p;
    for (int cyc = 0; cyc < n; cyc++) begin
      if (cyc > 0) @(negedge clk);
      txd = bits[cyc / (16 * p)];
      if (ir_tx) begin
        high++;
        if (!prev) begin
          rises++;
          if (first < 0) first = cyc;
        end
      end
      prev = ir_tx;
    end
    txd = 1'b1;
    if (mono_eff) begin
      check(rises == falls, "R6 pulse count", rises, falls);
      check(high == 6 * falls, "R6 width", high, 6 * falls);
      check(first == 16 + 1, "R6 start", first, 17);
    end else begin
      tag = mono ? "R8" : (p > 1 ? "R5" : "R3");
      check(rises == zeros, {tag, " R4 pulse per zero"}, rises, zeros);
      check(high == 3 * p * zeros, {tag, " R3 width"}, high, 3 * p * zeros);
      check(first == 16 * p + 7 * p + 1, {tag, " R3 offset"}, first, 23 * p + 1);
    end
  endtask

  task automatic run_rx(input int p, input int npulse, input int gap, input int lo_min,
                        input int lo_max, input string req);
    int low, first, total;
    use_baud_tick = (p > 1);
    align(p);
    low = 0; first = -1;
    total = npulse * gap + 20 * p + 10;
    for (int cyc = 0; cyc < total; cyc++) begin
      if (cyc > 0) @(negedge clk);
      ir_rx = (cyc % gap < 3) && (cyc / gap < npulse);
      if (!rxd) begin
        low++;
        if (first < 0) first = cyc;
      end
    end
    ir_rx = 1'b0;
    check(low >= lo_min && low <= lo_max, {req, " low length"}, low, lo_max);
    if (p == 1) check(first == 3, "R9 sync delay", first, 3);
  endtask

  initial begin
    int low, rises, high;
    bit prev;
    repeat (3) @(negedge clk);
    check(ir_tx == 1'b0, "R1 ir_tx in reset", ir_tx, 0);
    check(rxd == 1'b1, "R1 rxd in reset", rxd, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ir_tx == 1'b0 && rxd == 1'b1, "R1 after reset", {ir_tx, rxd}, 1);

    high = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ir_tx) high++;
    end
    check(high == 0, "R2 idle line dark", high, 0);

    foreach (p_list[k]) begin
      foreach (bytes[j]) run_tx(p_list[k], bytes[j], 1'b0);
    end
    foreach (bytes[j]) run_tx(1, bytes[j], 1'b1);
    run_tx(2, 8'h55, 1'b1);
    run_tx(3, 8'h0F, 1'b1);

    use_baud_tick = 1'b0; mono_en = 1'b1;
    align(1);
    rises = 0; high = 0; prev = 0;
    for (int cyc = 0; cyc < 30; cyc++) begin
      if (cyc > 0) @(negedge clk);
      txd = !(cyc == 0 || cyc == 1 || cyc >= 3 && cyc < 20);
      if (ir_tx) begin
        high++;
        if (!prev) rises++;
      end
      prev = ir_tx;
    end
    txd = 1'b1;
    check(rises == 1, "R7 single pulse", rises, 1);
    check(high == 6, "R7 no stretch", high, 6);
    mono_en = 1'b0;

    run_rx(1, 1, 40, 16, 16, "R9");
    run_rx(1, 4, 16, 64, 64, "R11");
    run_rx(1, 2, 8, 24, 24, "R12");
    run_rx(3, 1, 80, 15 * 3 + 1, 16 * 3, "R9 R5");

    use_baud_tick = 1'b0;
    align(1);
    low = 0;
    for (int cyc = 0; cyc < 30; cyc++) begin
      @(negedge clk);
      if (cyc == 2) begin
        #1 ir_rx = 1'b1;
        #2 ir_rx = 1'b0;
      end
      if (!rxd) low++;
    end
    check(low == 0, "R10 glitch ignored", low, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int p_list[4] = '{1, 2, 3, 5};
  logic [7:0] bytes[5] = '{8'h00, 8'hFF, 8'h55, 8'hA3, 8'h0F};

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule